// File: doc/BRIEF.md
# Memory Hole Remap Translator

The block turns a memory-controller-relative page number (4 KiB pages) into a system physical page number. Part of the physical space below 4 GiB is taken by a hole for device windows. The DRAM that would sit behind that hole is moved up to a window that starts at a programmable remap base. Three 16-bit settings describe this map: the top of low memory, the remap base and the remap limit. They are loaded through a small write port with a select field.

Each valid request produces one registered result a cycle later. Pages below the top of low memory pass through unchanged. So do pages at or above 4 GiB that lie below the remap base. Every other page is shifted by the hole offset into the remap window. If the shifted page reaches the remap limit, the block raises an error flag and returns a fixed fallback page, one below the top of low memory.

Top module: `hole_remap_xlate`

## Requirements
- R1: After reset, out_valid and out_err are 0 and all three settings are 0. A request made before any setting is written therefore reports an error with out_page = all ones.
- R2: A write with cfg_we=1 loads cfg_wdata into the setting picked by cfg_sel: 0 = top of low memory, 1 = remap base, 2 = remap limit. cfg_sel = 3 changes no setting. A write first affects requests presented in the following cycle.
- R3: The low threshold is the top-of-low-memory setting shifted left by 4. A page strictly below it is returned unchanged with out_err = 0.
- R4: The base page and the limit page are their settings shifted left by 14. A page that is at least 0x100000 and strictly below the base page is returned unchanged with out_err = 0.
- R5: Any other page is returned as page − low threshold + base page, with out_err = 0, when that value is strictly below the limit page.
- R6: When the remapped value is at or above the limit page, out_err = 1 and out_page = low threshold − 1, taken modulo 2^32. The sum is formed with a carry bit, so a sum that passes 2^32 counts as out of range.
- R7: out_valid is in_valid delayed by one clock. out_err is 1 only in a cycle where out_valid is 1.
- R8: A request presented in the same cycle as a setting write is translated with the settings as they were before that write.
- R9: While no request is presented, out_page keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select (0 low top, 1 remap base, 2 remap limit, 3 none) |
| cfg_wdata | input | 16 | Setting value |
| in_valid | input | 1 | Request strobe |
| in_page | input | 32 | Controller-relative page number |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_page | output | 32 | Physical page or fallback page |
| out_err | output | 1 | Remapped page out of range |

## Verification
A wrong setting register shows on the next request as a pass-through boundary in the wrong place, a wrong remap offset, or an error at the wrong page. The tests place pages exactly on each threshold so that an off-by-one or a wrong shift changes the result of the very next translation. A narrow sum shows only for pages near the top of the address space, so one test drives a page whose remapped value passes 2^32. Timing faults, such as a lost delay stage or a stray error pulse, show in the cycle right after a request.

// File: rtl/hole_remap_pkg.sv
package hole_remap_pkg;

  // select codes of the setting write port
  typedef enum logic [1:0] {
    CFG_LOW_TOP = 2'd0,
    CFG_REMAP_BASE = 2'd1,
    CFG_REMAP_LIMIT = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;

  // address region of a request
  typedef enum logic [1:0] {
    RGN_LOW = 2'd0,
    RGN_HIGH = 2'd1,
    RGN_REMAP = 2'd2
  } region_e;

endpackage

// File: rtl/hole_remap_cfg.sv
module hole_remap_cfg #(
  parameter int REG_W    = 16,
  parameter int PAGE_W   = 32,
  parameter int LOW_SH   = 4,
  parameter int REMAP_SH = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [PAGE_W-1:0] low_pg,
  output logic [PAGE_W-1:0] base_pg,
  output logic [PAGE_W-1:0] limit_pg
);
  localparam int NREG = 3;

  logic [NREG*REG_W-1:0] regs_flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (we && (sel == 2'(i))) q <= wdata;
    end
    assign regs_flat[i*REG_W +: REG_W] = q;
  end

  assign low_pg   = PAGE_W'(regs_flat[0*REG_W +: REG_W]) << LOW_SH;
  assign base_pg  = PAGE_W'(regs_flat[1*REG_W +: REG_W]) << REMAP_SH;
  assign limit_pg = PAGE_W'(regs_flat[2*REG_W +: REG_W]) << REMAP_SH;

endmodule

// File: rtl/hole_remap_calc.sv
module hole_remap_calc
  import hole_remap_pkg::*;
#(
  parameter int          PAGE_W = 32,
  parameter int unsigned HI_PG  = 32'h0010_0000
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] low_pg,
  input  logic [PAGE_W-1:0] base_pg,
  input  logic [PAGE_W-1:0] limit_pg,
  output logic [PAGE_W-1:0] res_page,
  output logic              res_err
);
  localparam int ACC_W = PAGE_W + 1;
  localparam logic [PAGE_W-1:0] HI = PAGE_W'(HI_PG);

  region_e          rgn;
  logic [ACC_W-1:0] sum;
  logic             over;

  always_comb begin
    if (page < low_pg)                    rgn = RGN_LOW;
    else if (page >= HI && page < base_pg) rgn = RGN_HIGH;
    else                                   rgn = RGN_REMAP;
  end

  // the carry bit keeps sums past the top of the page space out of range
  assign sum  = {1'b0, page} - {1'b0, low_pg} + {1'b0, base_pg};
  assign over = sum >= {1'b0, limit_pg};

  always_comb begin
    res_page = page;
    res_err  = 1'b0;
    case (rgn)
      RGN_LOW, RGN_HIGH: begin
        res_page = page;
        res_err  = 1'b0;
      end
      default: begin
        if (over) begin
          res_page = low_pg - PAGE_W'(1);
          res_err  = 1'b1;
        end else begin
          res_page = sum[PAGE_W-1:0];
          res_err  = 1'b0;
        end
      end
    endcase
  end

endmodule

// File: rtl/hole_remap_stage.sv
module hole_remap_stage #(
  parameter int PAGE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [PAGE_W-1:0] in_page,
  input  logic              in_err,
  output logic              q_vld,
  output logic [PAGE_W-1:0] q_page,
  output logic              q_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld  <= 1'b0;
      q_err  <= 1'b0;
      q_page <= '0;
    end else begin
      q_vld <= in_vld;
      q_err <= in_vld & in_err;
      if (in_vld) q_page <= in_page;
    end
  end
endmodule

// File: rtl/hole_remap_xlate.sv
module hole_remap_xlate #(
  parameter int          REG_W    = 16,
  parameter int          PAGE_W   = 32,
  parameter int          LOW_SH   = 4,
  parameter int          REMAP_SH = 14,
  parameter int unsigned HI_PG    = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  input  logic [PAGE_W-1:0] in_page,
  output logic              out_valid,
  output logic [PAGE_W-1:0] out_page,
  output logic              out_err
);
  logic [PAGE_W-1:0] low_pg, base_pg, limit_pg;
  logic [PAGE_W-1:0] res_page;
  logic              res_err;

  hole_remap_cfg #(
    .REG_W(REG_W), .PAGE_W(PAGE_W), .LOW_SH(LOW_SH), .REMAP_SH(REMAP_SH)
  ) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .low_pg(low_pg), .base_pg(base_pg), .limit_pg(limit_pg)
  );

  hole_remap_calc #(
    .PAGE_W(PAGE_W), .HI_PG(HI_PG)
  ) calc_i (
    .page(in_page), .low_pg(low_pg), .base_pg(base_pg), .limit_pg(limit_pg),
    .res_page(res_page), .res_err(res_err)
  );

  hole_remap_stage #(
    .PAGE_W(PAGE_W)
  ) stage_i (
    .clk(clk), .rst(rst), .in_vld(in_valid), .in_page(res_page),
    .in_err(res_err), .q_vld(out_valid), .q_page(out_page), .q_err(out_err)
  );

endmodule

// File: rtl/hole_remap_xlate_chk.sv
module hole_remap_xlate_chk #(
  parameter int          REG_W    = 16,
  parameter int          PAGE_W   = 32,
  parameter int          LOW_SH   = 4,
  parameter int unsigned HI_PG    = 32'h0010_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic              in_valid,
  input logic [PAGE_W-1:0] in_page,
  input logic              out_valid,
  input logic [PAGE_W-1:0] out_page,
  input logic              out_err,
  input logic [PAGE_W-1:0] low_pg,
  input logic [PAGE_W-1:0] base_pg,
  input logic [PAGE_W-1:0] limit_pg
);
  localparam logic [PAGE_W-1:0] HI = PAGE_W'(HI_PG);

  // R2
  low_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd0) |=> low_pg == (PAGE_W'($past(cfg_wdata)) << LOW_SH));

  // R3
  low_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_page < low_pg) |=> (!out_err && out_page == $past(in_page)));

  // R4
  high_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_page >= HI && in_page < base_pg) |=> (!out_err && out_page == $past(in_page)));

  // R5
  remap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_page >= low_pg && !(in_page >= HI && in_page < base_pg))
      |=> (out_err || out_page < $past(limit_pg)));

  // R6
  fallback_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!out_err || out_page == $past(low_pg) - PAGE_W'(1)));

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_page));

endmodule

bind hole_remap_xlate hole_remap_xlate_chk #(
  .REG_W(REG_W), .PAGE_W(PAGE_W), .LOW_SH(LOW_SH), .HI_PG(HI_PG)
) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_page(in_page),
  .out_valid(out_valid), .out_page(out_page), .out_err(out_err),
  .low_pg(low_pg), .base_pg(base_pg), .limit_pg(limit_pg)
);

// File: tb/hole_remap_xlate_tb_top.sv
module hole_remap_xlate_tb_top;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_page = '0;
  logic        out_valid;
  logic [31:0] out_page;
  logic        out_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  longint sh_low = 0, sh_base = 0, sh_limit = 0;

  always #(CLK_P/2) clk = ~clk;

  hole_remap_xlate dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_page(in_page),
    .out_valid(out_valid), .out_page(out_page), .out_err(out_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input longint pg, output longint ep, output bit ee);
    longint t, b, l, r;
    t = sh_low << 4;
    b = sh_base << 14;
    l = sh_limit << 14;
    if (pg < t || (pg >= 64'h10_0000 && pg < b)) begin
      ep = pg; ee = 1'b0;
    end else begin
      r = pg - t + b;
      if (r < l) begin ep = r; ee = 1'b0; end
      else begin ep = (t - 1) & 64'hFFFF_FFFF; ee = 1'b1; end
    end
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: sh_low = longint'(val);
      2'd1: sh_base = longint'(val);
      2'd2: sh_limit = longint'(val);
      default: ;
    endcase
  endtask

  task automatic xl(input longint pg, input string req);
    longint ep; bit ee;
    model(pg, ep, ee);
    @(negedge clk);
    in_valid = 1'b1; in_page = pg[31:0];
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, req, "valid", longint'(out_valid), 1);
    check(longint'(out_page) == ep, req, "page", longint'(out_page), ep);
    check(out_err == ee, req, "err", longint'(out_err), longint'(ee));
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", "valid after reset", longint'(out_valid), 0);
    check(out_err == 1'b0, "R1", "err after reset", longint'(out_err), 0);
    xl(5, "R1");
    check(out_page == 32'hFFFF_FFFF, "R1", "fallback at zero setting",
          longint'(out_page), 64'hFFFF_FFFF);
  endtask

  task automatic t_setup();
    cfg_write(2'd0, 16'hC000);  // low top page 0xC0000
    cfg_write(2'd1, 16'h0048);  // base page 0x120000
    cfg_write(2'd2, 16'h0050);  // limit page 0x140000
    xl(64'hBFFFF, "R2");
  endtask

  task automatic t_low();
    xl(0, "R3");
    xl(64'h1234, "R3");
    xl(64'hBFFFF, "R3");
  endtask

  task automatic t_high();
    xl(64'h10_0000, "R4");
    xl(64'h11_FFFF, "R4");
    xl(64'h12_0000, "R4");  // at base: remapped, past limit
  endtask

  task automatic t_remap();
    xl(64'hC0000, "R5");
    check(out_page == 32'h0012_0000, "R5", "first hole page", longint'(out_page), 64'h12_0000);
    xl(64'hDFFFF, "R5");
    xl(64'hD0000, "R5");
  endtask

  task automatic t_limit();
    xl(64'hE0000, "R6");
    check(out_err == 1'b1, "R6", "exact limit", longint'(out_err), 1);
    check(out_page == 32'h000B_FFFF, "R6", "fallback", longint'(out_page), 64'hBFFFF);
    xl(64'hFFFFF, "R6");
  endtask

  task automatic t_overflow();
    cfg_write(2'd0, 16'hFFFF);
    cfg_write(2'd1, 16'hFFFF);
    cfg_write(2'd2, 16'hFFFF);
    xl(64'hFFFF_FFFF, "R6");
    check(out_err == 1'b1, "R6", "carry past 2^32", longint'(out_err), 1);
    xl(64'h1_0000, "R3");
  endtask

  task automatic t_sel_none();
    cfg_write(2'd3, 16'h0001);
    xl(64'hFFFEF, "R2");  // just below low threshold 0xFFFF0
    xl(64'hFFFF0, "R2");
  endtask

  task automatic t_same_cycle();
    longint ep; bit ee;
    model(64'h8_0000, ep, ee);  // old low threshold 0xFFFF0: pass-through
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h4000;
    in_valid = 1'b1; in_page = 32'h0008_0000;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    sh_low = 64'h4000;
    check(out_page == ep[31:0], "R8", "old setting used", longint'(out_page), ep);
    check(out_err == ee, "R8", "old setting err", longint'(out_err), longint'(ee));
    xl(64'h8_0000, "R8");
  endtask

  task automatic t_timing();
    longint ea, eb; bit xa, xb;
    cfg_write(2'd0, 16'hC000);
    cfg_write(2'd1, 16'h0048);
    cfg_write(2'd2, 16'h0050);
    model(64'hC0010, ea, xa);
    model(64'hFFFFF, eb, xb);
    @(negedge clk);
    in_valid = 1'b1; in_page = 32'h000C_0010;
    @(negedge clk);
    in_page = 32'h000F_FFFF;
    check(out_valid == 1'b1, "R7", "first valid", longint'(out_valid), 1);
    check(out_page == ea[31:0], "R7", "first page", longint'(out_page), ea);
    check(out_err == 1'b0, "R7", "first err", longint'(out_err), 0);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R7", "second valid", longint'(out_valid), 1);
    check(out_page == eb[31:0], "R7", "second page", longint'(out_page), eb);
    check(out_err == xb, "R7", "second err", longint'(out_err), longint'(xb));
    @(negedge clk);
    in_page = 32'h0000_0007;
    check(out_valid == 1'b0, "R7", "valid drops", longint'(out_valid), 0);
    check(out_err == 1'b0, "R7", "err drops", longint'(out_err), 0);
    check(out_page == eb[31:0], "R9", "page held", longint'(out_page), eb);
    @(negedge clk);
    check(out_page == eb[31:0], "R9", "page held idle input", longint'(out_page), eb);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_setup();
    t_low();
    t_high();
    t_remap();
    t_limit();
    t_overflow();
    t_sel_none();
    t_same_cycle();
    t_timing();
    finish_run();
  end

endmodule